// File: doc/BRIEF.md
# DDR SDRAM Initialization Sequencer

This block brings a DDR SDRAM device from power-up to the point where it can accept normal traffic. A one-cycle start pulse sets it off. It then drives clock enable, the four command strobes, the bank address and a 13-bit address bus through a fixed series of steps. CKE is held low first. Then CKE rises and a precharge of all banks follows. The extended mode register is loaded with the DLL enabled. The mode register is loaded with the DLL reset bit set. A second precharge and two auto refreshes come next, and a final mode register load clears the DLL reset bit. Each command is followed by a cycle-counted wait, and the command bus carries NOP during every wait.

The burst length, CAS latency code and reduced-drive option are captured when the start pulse is accepted. They are placed into the mode words at fixed bit positions, because the device decodes those positions. A lock counter starts when the DLL is enabled. The ready flag rises only when this counter has covered the lock window and the final mode-load wait has ended. After that the block holds CKE high and idles the bus with NOP until reset. It has no data stream, so every pin is a plain level or pulse. All timing values are elaboration parameters counted in clock cycles.

Top module: `ddr_init_seq`

## Requirements
- R1: During reset and afterwards until a start pulse is seen, cke_o is low, the bus carries NOP, ready_o is low, and ba_o and addr_o are zero.
- R2: CKE stays low with NOP for T_CKE_LOW cycles, starting in the cycle after the start pulse is sampled. It then rises and stays high until the next reset.
- R3: Exactly seven commands are issued, in this order: precharge-all, extended mode load, mode load with DLL reset, precharge-all, refresh, refresh, mode load without DLL reset.
- R4: Command encodings on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, mode load 0000, precharge 0010, refresh 0001. A precharge drives address bit 10 high, which selects all banks.
- R5: Each command lasts one cycle. The next command comes exactly T_MRD cycles after a mode or extended-mode load, T_RP cycles after a precharge and T_RFC cycles after a refresh. The first precharge comes T_CKE_UP cycles after CKE rises.
- R6: Every cycle that issues no command carries NOP, with ba_o and addr_o all zero.
- R7: The extended mode load drives ba_o = 01 (BA0 high). Its address has bit 0 low (DLL enabled), bit 1 equal to the captured reduced-drive option, and all other bits zero.
- R8: Mode loads drive ba_o = 00. The address carries the burst length code in bits 2:0, a zero (sequential) in bit 3 and the CAS latency code in bits 6:4 (010 means 2, 110 means 2.5). Bit 8 is set on the first mode load and clear on the last. All other bits are zero.
- R9: The command that follows the DLL-enabling extended load is always the mode load with the DLL reset bit set.
- R10: ready_o first rises in cycle max(M + T_MRD, E + T_LOCK), where E is the extended-load cycle and M the final mode-load cycle. It never rises earlier and stays high until reset.
- R11: Changes to the configuration inputs after start, and further start pulses while the sequence runs, have no effect on any output.
- R12: Once ready_o is high, cke_o stays high and the bus carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| cas_lat_i | input | 3 | CAS latency code for mode bits 6:4 |
| burst_len_i | input | 3 | Burst length code for mode bits 2:0 |
| reduced_drive_i | input | 1 | Reduced output drive option for extended bit 1 |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address bus / mode word |
| ready_o | output | 1 | Device ready for normal traffic |

## Verification
A wrong step counter or a corrupted state shows up at the ports in the very cycle it takes effect. A command lands at the wrong offset, appears in a wait window or goes missing, so every cycle of the sequence is compared against a computed timeline. A mis-captured configuration or a wrong mode-word field shows up in the one cycle of the affected load. A fault in the lock counter may only show much later, when ready_o rises too early or too late, so the ready cycle is checked against its exact expected value.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CKE_LOW,
    ST_CKE_UP,
    ST_PRE_A,
    ST_EXT_LOAD,
    ST_MODE_RST,
    ST_PRE_B,
    ST_REF_A,
    ST_REF_B,
    ST_MODE_RUN,
    ST_READY
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOAD = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } bus_cmd_t;

  localparam int BIT_EXT_DLL_OFF = 0;
  localparam int BIT_EXT_WEAK    = 1;
  localparam int BIT_BL_LSB      = 0;
  localparam int BIT_BTYPE       = 3;
  localparam int BIT_CL_LSB      = 4;
  localparam int BIT_DLL_RST     = 8;
  localparam int BIT_ALL_BANKS   = 10;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
  parameter int T_LOCK = 200,
  localparam int LW = $clog2(T_LOCK + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cke_i,
  output logic near_o,
  output logic full_o
);
  logic          armed_q;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (arm_i) armed_q <= 1'b1;
      if ((armed_q || arm_i) && cke_i && cnt_q != LW'(T_LOCK))
        cnt_q <= cnt_q + LW'(1);
    end
  end

  // near: the window completes at the next clock edge or has already completed
  assign near_o = armed_q && (cnt_q >= LW'(T_LOCK - 1));
  assign full_o = (cnt_q == LW'(T_LOCK));

  assert_full_needs_arm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> armed_q);
endmodule

// File: rtl/ddr_init_mode_word.sv
module ddr_init_mode_word
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        burst_len_i,
  input  logic              reduced_drive_i,
  input  logic              dll_reset_i,
  input  logic              ext_sel_i,
  output logic [ADDR_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    if (ext_sel_i) begin
      word_o[BIT_EXT_DLL_OFF] = 1'b0;
      word_o[BIT_EXT_WEAK]    = reduced_drive_i;
    end else begin
      word_o[BIT_BL_LSB +: 3] = burst_len_i;
      word_o[BIT_BTYPE]       = 1'b0;
      word_o[BIT_CL_LSB +: 3] = cas_lat_i;
      word_o[BIT_DLL_RST]     = dll_reset_i;
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int T_CKE_LOW = 20,
  parameter int T_CKE_UP  = 2,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 8,
  parameter int T_LOCK    = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        burst_len_i,
  input  logic              reduced_drive_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o
);
  localparam int D_A   = (T_CKE_LOW > T_CKE_UP) ? T_CKE_LOW : T_CKE_UP;
  localparam int D_B   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int D_C   = (D_A > D_B) ? D_A : D_B;
  localparam int D_MAX = (D_C > T_RFC) ? D_C : T_RFC;
  localparam int TMR_W = $clog2(D_MAX + 1);

  seq_state_t state_q, state_nx;
  logic       first_q;
  logic       advance, tmr_expired, lock_near, lock_full;
  logic [TMR_W-1:0] dwell_nx;
  logic [2:0] cl_q, bl_q;
  logic       rd_q;
  bus_cmd_t   cmd;
  logic       issue;
  logic [ADDR_W-1:0] mode_word;
  logic       dll_due_q;

  function automatic seq_state_t succ(seq_state_t s);
    case (s)
      ST_IDLE:     return ST_CKE_LOW;
      ST_CKE_LOW:  return ST_CKE_UP;
      ST_CKE_UP:   return ST_PRE_A;
      ST_PRE_A:    return ST_EXT_LOAD;
      ST_EXT_LOAD: return ST_MODE_RST;
      ST_MODE_RST: return ST_PRE_B;
      ST_PRE_B:    return ST_REF_A;
      ST_REF_A:    return ST_REF_B;
      ST_REF_B:    return ST_MODE_RUN;
      default:     return ST_READY;
    endcase
  endfunction

  function automatic logic [TMR_W-1:0] dwell(seq_state_t s);
    case (s)
      ST_CKE_LOW:               return TMR_W'(T_CKE_LOW);
      ST_CKE_UP:                return TMR_W'(T_CKE_UP);
      ST_PRE_A, ST_PRE_B:       return TMR_W'(T_RP);
      ST_REF_A, ST_REF_B:       return TMR_W'(T_RFC);
      ST_EXT_LOAD, ST_MODE_RST,
      ST_MODE_RUN:              return TMR_W'(T_MRD);
      default:                  return TMR_W'(1);
    endcase
  endfunction

  function automatic bus_cmd_t step_cmd(seq_state_t s);
    case (s)
      ST_PRE_A, ST_PRE_B:                    return CMD_PRE;
      ST_REF_A, ST_REF_B:                    return CMD_REF;
      ST_EXT_LOAD, ST_MODE_RST, ST_MODE_RUN: return CMD_LOAD;
      default:                               return CMD_NOP;
    endcase
  endfunction

  // ---------------- step control ----------------
  always_comb begin
    case (state_q)
      ST_IDLE:     advance = start_i;
      ST_READY:    advance = 1'b0;
      ST_MODE_RUN: advance = tmr_expired && lock_near;
      default:     advance = tmr_expired;
    endcase
    state_nx = succ(state_q);
    dwell_nx = dwell(state_nx);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      first_q <= advance;
      if (advance) state_q <= state_nx;
    end
  end

  // configuration captured once, when the start pulse is accepted
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cl_q <= '0;
      bl_q <= '0;
      rd_q <= 1'b0;
    end else if (state_q == ST_IDLE && start_i) begin
      cl_q <= cas_lat_i;
      bl_q <= burst_len_i;
      rd_q <= reduced_drive_i;
    end
  end

  ddr_init_timer #(.W(TMR_W)) u_step_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (advance),
    .len_i     (dwell_nx),
    .expired_o (tmr_expired)
  );

  ddr_init_lock #(.T_LOCK(T_LOCK)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (issue && state_q == ST_EXT_LOAD),
    .cke_i  (cke_o),
    .near_o (lock_near),
    .full_o (lock_full)
  );

  ddr_init_mode_word #(.ADDR_W(ADDR_W)) u_mode_word (
    .cas_lat_i       (cl_q),
    .burst_len_i     (bl_q),
    .reduced_drive_i (rd_q),
    .dll_reset_i     (state_q == ST_MODE_RST),
    .ext_sel_i       (state_q == ST_EXT_LOAD),
    .word_o          (mode_word)
  );

  // ---------------- command bus ----------------
  always_comb begin
    cmd    = first_q ? step_cmd(state_q) : CMD_NOP;
    issue  = (cmd != CMD_NOP);
    addr_o = '0;
    ba_o   = '0;
    case (cmd)
      CMD_LOAD: begin
        addr_o = mode_word;
        if (state_q == ST_EXT_LOAD) ba_o = BA_W'(1);
      end
      CMD_PRE: addr_o[BIT_ALL_BANKS] = 1'b1;
      default: ;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cke_o   = (state_q != ST_IDLE) && (state_q != ST_CKE_LOW);
  assign ready_o = (state_q == ST_READY);

  // tracks that the DLL was just enabled and its reset load is owed
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                              dll_due_q <= 1'b0;
    else if (issue && state_q == ST_EXT_LOAD) dll_due_q <= 1'b1;
    else if (issue)                           dll_due_q <= 1'b0;
  end

  // ---------------- assertions ----------------
  assert_nop_while_cke_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));

  assert_cke_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  assert_spacing_respected_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> $past(tmr_expired));

  assert_dll_reset_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && dll_due_q) |-> (cmd == CMD_LOAD && ba_o == '0 && addr_o[BIT_DLL_RST]));

  assert_ready_after_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> lock_full);

  assert_ready_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  assert_idle_bus_when_ready_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!issue && cke_o));
endmodule

// File: tb/test_ddr_init_seq.sv
`timescale 1ns/1ps
module test_ddr_init_seq;
  localparam int T_CKE_LOW = 20;
  localparam int T_CKE_UP  = 2;
  localparam int T_RP      = 3;
  localparam int T_MRD     = 2;
  localparam int T_RFC     = 8;
  localparam int T_LOCK    = 200;

  // expected command offsets, counted from the cycle after start is sampled
  localparam int K_UP = T_CKE_LOW;
  localparam int K0 = K_UP + T_CKE_UP;
  localparam int K1 = K0 + T_RP;
  localparam int K2 = K1 + T_MRD;
  localparam int K3 = K2 + T_MRD;
  localparam int K4 = K3 + T_RP;
  localparam int K5 = K4 + T_RFC;
  localparam int K6 = K5 + T_RFC;
  localparam int K_RDY = ((K6 + T_MRD) > (K1 + T_LOCK)) ? (K6 + T_MRD) : (K1 + T_LOCK);
  localparam int SPAN = K_RDY + 20;

  // vector table: offset, command code, address kind (0 pre,1 ext,2 mode+rst,3 ref,4 mode)
  localparam int       NEV = 7;
  localparam int       EV_OFF  [NEV] = '{K0, K1, K2, K3, K4, K5, K6};
  localparam bit [3:0] EV_CMD  [NEV] = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
  localparam int       EV_KIND [NEV] = '{0, 1, 2, 0, 3, 3, 4};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] cl = 3'b010, bl = 3'b010;
  logic rd = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [1:0] ba;
  logic [12:0] addr;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ddr_init_seq #(
    .T_CKE_LOW(T_CKE_LOW), .T_CKE_UP(T_CKE_UP), .T_RP(T_RP),
    .T_MRD(T_MRD), .T_RFC(T_RFC), .T_LOCK(T_LOCK)
  ) i_ddr_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cas_lat_i(cl), .burst_len_i(bl), .reduced_drive_i(rd),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_addr(int kind, logic [2:0] c, logic [2:0] b, logic r);
    logic [12:0] a = '0;
    case (kind)
      0: a[10] = 1'b1;
      1: a[1] = r;
      2: begin a[2:0] = b; a[6:4] = c; a[8] = 1'b1; end
      4: begin a[2:0] = b; a[6:4] = c; end
      default: ;
    endcase
    return a;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk(!cke && !ready && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == 0 && ba == 0,
        "R1 in reset", {cke, ready, cs_n, ras_n, cas_n, we_n}, 6'b000111);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle without start
    chk(!cke && !ready && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == 0 && ba == 0,
        "R1 idle", {cke, ready, cs_n, ras_n, cas_n, we_n, addr}, {6'b000111, 13'h0});
  endtask

  task automatic run_case(input logic [2:0] c, input logic [2:0] b, input logic r, input bit disturb);
    int nseen = 0, cke_err = 0, rdy_err = 0, nop_err = 0, first_rdy = -1;
    int k_seen [16];
    logic [3:0] c_seen [16];
    logic [1:0] b_seen [16];
    logic [12:0] a_seen [16];
    do_reset();
    cl = c; bl = b; rd = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < SPAN; k++) begin
      if (cke !== (k >= K_UP)) cke_err++;                    // R2
      if (ready !== (k >= K_RDY)) rdy_err++;                 // R10
      if (ready && first_rdy < 0) first_rdy = k;
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (nseen < 16) begin
          k_seen[nseen] = k; c_seen[nseen] = {cs_n, ras_n, cas_n, we_n};
          b_seen[nseen] = ba; a_seen[nseen] = addr;
        end
        nseen++;
      end else if (addr != 0 || ba != 0) nop_err++;          // R6
      if (disturb && k == 3) begin cl = ~c; bl = ~b; rd = ~r; end  // R11
      if (disturb && (k == 5 || k == 30)) start = 1'b1;       // R11
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cke_err == 0, "R2 cke timeline", cke_err, 0);
    chk(rdy_err == 0, "R10 ready timeline", first_rdy, K_RDY);
    chk(nop_err == 0, "R6 nop bus zero", nop_err, 0);
    chk(nseen == NEV, "R3 command count", nseen, NEV);
    for (int i = 0; i < NEV; i++) begin
      if (i < nseen) begin
        chk(k_seen[i] == EV_OFF[i], "R5 command offset", k_seen[i], EV_OFF[i]);
        chk(c_seen[i] == EV_CMD[i], "R3/R4 command code", c_seen[i], EV_CMD[i]);
        chk(b_seen[i] == ((EV_KIND[i] == 1) ? 2'b01 : 2'b00), "R7/R8 bank", b_seen[i],
            (EV_KIND[i] == 1) ? 2'b01 : 2'b00);
        chk(a_seen[i] == exp_addr(EV_KIND[i], c, b, r), "R7/R8/R11 address",
            a_seen[i], exp_addr(EV_KIND[i], c, b, r));
      end
    end
    // R9: command right after the extended load carries DLL reset
    if (nseen > 2) chk(c_seen[2] == 4'b0000 && a_seen[2][8], "R9 dll reset next", a_seen[2], 13'h100);
    // R12: quiet bus after ready
    chk(ready && cke && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R12 ready idle",
        {ready, cke, cs_n, ras_n, cas_n, we_n}, 6'b110111);
  endtask

  initial begin
    run_case(3'b010, 3'b010, 1'b0, 1'b0);   // CL 2, BL 4, full drive
    run_case(3'b110, 3'b011, 1'b1, 1'b1);   // CL 2.5, BL 8, reduced drive, disturbed
    run_case(3'b010, 3'b001, 1'b1, 1'b0);   // CL 2, BL 2, reduced drive
    // R1: reset after ready returns to idle
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ready && !cke, "R1 reset after ready", {ready, cke}, 2'b00);
    rst_n = 1'b1;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule